// File: doc/BRIEF.md
# Extended DSP Register and DMA Run Controller

This block sits behind the byte-wide command port of a sound DSP. It picks out the extended command family (codes 0xA0 through 0xCF) from the host byte stream and keeps a small bank of extended control registers. From those registers it drives the control outputs of a DMA engine: whether requests may run, the sample format, the loop and direction flags, the transfer length and the sample-rate clock selection and divisor.

Host bytes arrive one per cycle on a valid strobe. A command byte that needs an operand is followed by exactly one data byte. Register read-back leaves the block on a one-cycle output strobe. The block decides when the DMA engine starts and stops. When a setting the engine depends on is changed while a transfer is running, it issues a stop pulse and then a start pulse on the next cycle, so the engine reloads with the new settings.

Top module: `ext_dsp_dma`

## Requirements
- R1: Command byte 0xC6 enables extended mode and 0xC7 disables it. Neither one consumes a data byte. Extended mode is off after reset.
- R2: Commands 0xA0 to 0xBF consume the next byte as data. That data is written to the register whose number equals the command, but only while extended mode is on. Otherwise the write is dropped. Bytes outside 0xA0 to 0xCF, and 0xC1 to 0xCF other than 0xC6 and 0xC7, are ignored and consume no data byte.
- R3: Command 0xC0 consumes one byte, a register number. The block returns one byte with a one-cycle rd_valid pulse, two rising edges after that byte is sampled. Registers 0xA1, 0xA2, 0xA4, 0xA5, 0xA8, 0xB1, 0xB2, 0xB5, 0xB6, 0xB7, 0xB8, 0xB9, 0xBA and 0xBB return their content. Every other number returns 0xFF. A read works whether extended mode is on or off.
- R4: In registers 0xB1 and 0xB2 only bits 7:4 take written data and bits 3:0 keep their value. Register 0xB8 keeps only bits 3:0 and reads bits 7:4 as zero.
- R5: fmt_16bit, fmt_stereo and fmt_signed follow bits 2, 3 and 5 of register 0xB7. auto_init follows bit 2 of 0xB8 and capture follows bit 3 of 0xB8. Each output changes on the second rising edge after the data byte is sampled.
- R6: xfer_len equals 0x10000 minus {reg 0xA5, reg 0xA4}, as a 17-bit value, so a reload value of zero gives 0x10000.
- R7: rate_hiclk equals bit 7 of register 0xA1. rate_div is 256 minus the register value when that bit is set, and 128 minus the register value when it is clear.
- R8: The run condition is bit 0 of 0xB8 AND bit 6 of 0xB2. When a write makes it true, dma_start pulses for one cycle and dma_req rises. When a write makes it false, dma_stop pulses and dma_req falls. Both happen on the third rising edge after the data byte is sampled.
- R9: While running, the block restarts on any of these writes: a write that changes bits 3:2 of 0xB7, a write that changes bits 1:0 of 0xA8, any write to 0xA1, or a write that changes bit 1 or bit 3 of 0xB8. A restart is a one-cycle dma_stop on the third edge. If the run condition still holds, a one-cycle dma_start follows on the next edge, with dma_req low between the two pulses.
- R10: While running, a write that changes only other bits does not pulse dma_stop or dma_start. This covers bit 5 of 0xB7, bit 2 of 0xB8, and bits other than 1:0 of 0xA8.
- R11: After reset all extended registers are zero. dma_req, dma_start, dma_stop and rd_valid are low, xfer_len is 0x10000 and rate_div is 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host byte valid |
| host_byte | input | 8 | Host command or data byte |
| rd_valid | output | 1 | Read-back byte valid, one cycle |
| rd_byte | output | 8 | Read-back byte |
| dma_req | output | 1 | DMA requests allowed (engine running) |
| dma_start | output | 1 | One-cycle start/reload pulse |
| dma_stop | output | 1 | One-cycle stop pulse |
| fmt_16bit | output | 1 | 16-bit samples |
| fmt_stereo | output | 1 | Stereo samples |
| fmt_signed | output | 1 | Signed sample data |
| auto_init | output | 1 | Auto-reload transfer mode |
| capture | output | 1 | Capture direction (ADC) instead of playback |
| xfer_len | output | 17 | Transfer length in transfers |
| rate_hiclk | output | 1 | Fast rate clock selected |
| rate_div | output | 8 | Rate divisor |

## Verification
If the register bank holds a wrong value, a read-back byte or one of the format, length or rate outputs shows it two edges after the offending data byte. A parser that loses its place between command and data bytes shows up within one command, as a write landing in the wrong register or a read that never comes back. A wrong run state shows as a missing, extra or misplaced dma_start or dma_stop pulse, or a wrong dma_req level, on the third edge after the write. These outputs are compared against a reference model on every cycle, so such an error is caught in the cycle it first appears.

// File: rtl/ext_dsp_pkg.sv
package ext_dsp_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_SLOTS = 14;
    localparam int CNT_W     = 2 * BYTE_W;
    localparam int LEN_W     = CNT_W + 1;

    // command codes
    localparam logic [BYTE_W-1:0] CMD_EXT_ON  = 8'hC6;
    localparam logic [BYTE_W-1:0] CMD_EXT_OFF = 8'hC7;
    localparam logic [BYTE_W-1:0] CMD_READ    = 8'hC0;
    localparam logic [BYTE_W-1:0] CMD_WR_LO   = 8'hA0;
    localparam logic [BYTE_W-1:0] CMD_WR_HI   = 8'hBF;

    // extended register numbers
    localparam logic [BYTE_W-1:0] REG_RATE    = 8'hA1;
    localparam logic [BYTE_W-1:0] REG_FILT    = 8'hA2;
    localparam logic [BYTE_W-1:0] REG_CNT_LO  = 8'hA4;
    localparam logic [BYTE_W-1:0] REG_CNT_HI  = 8'hA5;
    localparam logic [BYTE_W-1:0] REG_ANALOG  = 8'hA8;
    localparam logic [BYTE_W-1:0] REG_IRQ_CTL = 8'hB1;
    localparam logic [BYTE_W-1:0] REG_DRQ_CTL = 8'hB2;
    localparam logic [BYTE_W-1:0] REG_DAC_LO  = 8'hB5;
    localparam logic [BYTE_W-1:0] REG_DAC_HI  = 8'hB6;
    localparam logic [BYTE_W-1:0] REG_FMT     = 8'hB7;
    localparam logic [BYTE_W-1:0] REG_XFER    = 8'hB8;
    localparam logic [BYTE_W-1:0] REG_TTYPE   = 8'hB9;
    localparam logic [BYTE_W-1:0] REG_OFS_L   = 8'hBA;
    localparam logic [BYTE_W-1:0] REG_OFS_R   = 8'hBB;

    // storage slots
    localparam int SLOT_RATE    = 0;
    localparam int SLOT_FILT    = 1;
    localparam int SLOT_CNT_LO  = 2;
    localparam int SLOT_CNT_HI  = 3;
    localparam int SLOT_ANALOG  = 4;
    localparam int SLOT_IRQ_CTL = 5;
    localparam int SLOT_DRQ_CTL = 6;
    localparam int SLOT_DAC_LO  = 7;
    localparam int SLOT_DAC_HI  = 8;
    localparam int SLOT_FMT     = 9;
    localparam int SLOT_XFER    = 10;
    localparam int SLOT_TTYPE   = 11;
    localparam int SLOT_OFS_L   = 12;
    localparam int SLOT_OFS_R   = 13;

    // field positions the controller decodes
    localparam int FMT_WIDE_BIT    = 2;
    localparam int FMT_STEREO_BIT  = 3;
    localparam int FMT_SIGNED_BIT  = 5;
    localparam int XFER_EN_BIT     = 0;
    localparam int XFER_DIR_BIT    = 1;
    localparam int XFER_AUTO_BIT   = 2;
    localparam int XFER_ADC_BIT    = 3;
    localparam int DRQ_GATE_BIT    = 6;
    localparam int RATE_CLKSEL_BIT = 7;

    typedef struct packed {
        logic [BYTE_W-1:0] rate;
        logic [CNT_W-1:0]  count;
        logic              drq_gate;
        logic              xfer_en;
        logic              auto_init;
        logic              capture;
        logic              wide;
        logic              stereo;
        logic              sgn;
    } ctrl_view_t;

    function automatic logic [BYTE_W-1:0] slot_addr(input int unsigned idx);
        case (idx)
            SLOT_RATE:    return REG_RATE;
            SLOT_FILT:    return REG_FILT;
            SLOT_CNT_LO:  return REG_CNT_LO;
            SLOT_CNT_HI:  return REG_CNT_HI;
            SLOT_ANALOG:  return REG_ANALOG;
            SLOT_IRQ_CTL: return REG_IRQ_CTL;
            SLOT_DRQ_CTL: return REG_DRQ_CTL;
            SLOT_DAC_LO:  return REG_DAC_LO;
            SLOT_DAC_HI:  return REG_DAC_HI;
            SLOT_FMT:     return REG_FMT;
            SLOT_XFER:    return REG_XFER;
            SLOT_TTYPE:   return REG_TTYPE;
            SLOT_OFS_L:   return REG_OFS_L;
            default:      return REG_OFS_R;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] write_mask(input logic [BYTE_W-1:0] addr);
        case (addr)
            REG_IRQ_CTL, REG_DRQ_CTL: return 8'hF0;
            REG_XFER:                 return 8'h0F;
            default:                  return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/ext_cmd_parser.sv
module ext_cmd_parser
    import ext_dsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic [BYTE_W-1:0] acc_addr,
    output logic [BYTE_W-1:0] acc_data
);

    typedef struct packed {
        logic              ext_on;
        logic              wait_data;
        logic [BYTE_W-1:0] cmd;
        logic              wr;
        logic              rd;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } parse_t;

    parse_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.wr = 1'b0;
        st_d.rd = 1'b0;
        if (in_valid) begin
            if (st_q.wait_data) begin
                st_d.wait_data = 1'b0;
                if (st_q.cmd == CMD_READ) begin
                    st_d.rd   = 1'b1;
                    st_d.addr = in_byte;
                end else if (st_q.ext_on) begin
                    st_d.wr   = 1'b1;
                    st_d.addr = st_q.cmd;
                    st_d.data = in_byte;
                end
            end else if ((in_byte >= CMD_WR_LO && in_byte <= CMD_WR_HI) ||
                         in_byte == CMD_READ) begin
                st_d.wait_data = 1'b1;
                st_d.cmd       = in_byte;
            end else if (in_byte == CMD_EXT_ON) begin
                st_d.ext_on = 1'b1;
            end else if (in_byte == CMD_EXT_OFF) begin
                st_d.ext_on = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_stb   = st_q.wr;
    assign rd_stb   = st_q.rd;
    assign acc_addr = st_q.addr;
    assign acc_data = st_q.data;

    // every access needs a command byte and a data byte, so strobes never sit back to back
    assert_strobe_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || rd_stb) |=> !(wr_stb || rd_stb));

    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && rd_stb));

endmodule

// File: rtl/ext_reg_bank.sv
module ext_reg_bank
    import ext_dsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [BYTE_W-1:0] acc_addr,
    input  logic [BYTE_W-1:0] acc_data,
    output ctrl_view_t        view,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              reinit
);

    typedef struct packed {
        logic [NUM_SLOTS-1:0][BYTE_W-1:0] regs;
        logic                             rd_valid;
        logic [BYTE_W-1:0]                rd_byte;
        logic                             reinit;
    } bank_t;

    bank_t st_d, st_q;

    logic [NUM_SLOTS-1:0] hit;
    logic                 any_hit;
    logic [BYTE_W-1:0]    old_val;
    logic [BYTE_W-1:0]    new_val;
    logic [BYTE_W-1:0]    chg;
    logic [BYTE_W-1:0]    mask;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign hit[g] = (acc_addr == slot_addr(g));
    end

    assign any_hit = |hit;
    assign mask    = write_mask(acc_addr);

    always_comb begin
        old_val = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (hit[i]) old_val = old_val | st_q.regs[i];
        end
        new_val = (old_val & ~mask) | (acc_data & mask);
        chg     = old_val ^ new_val;
    end

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        st_d.reinit   = 1'b0;
        if (wr_stb && any_hit) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (hit[i]) st_d.regs[i] = new_val;
            end
            unique case (acc_addr)
                REG_FMT:    st_d.reinit = chg[FMT_WIDE_BIT] | chg[FMT_STEREO_BIT];
                REG_ANALOG: st_d.reinit = |chg[1:0];
                REG_RATE:   st_d.reinit = 1'b1;
                REG_XFER:   st_d.reinit = chg[XFER_DIR_BIT] | chg[XFER_ADC_BIT];
                default:    st_d.reinit = 1'b0;
            endcase
        end
        if (rd_stb) begin
            st_d.rd_valid = 1'b1;
            st_d.rd_byte  = any_hit ? old_val : 8'hFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        view.rate      = st_q.regs[SLOT_RATE];
        view.count     = {st_q.regs[SLOT_CNT_HI], st_q.regs[SLOT_CNT_LO]};
        view.drq_gate  = st_q.regs[SLOT_DRQ_CTL][DRQ_GATE_BIT];
        view.xfer_en   = st_q.regs[SLOT_XFER][XFER_EN_BIT];
        view.auto_init = st_q.regs[SLOT_XFER][XFER_AUTO_BIT];
        view.capture   = st_q.regs[SLOT_XFER][XFER_ADC_BIT];
        view.wide      = st_q.regs[SLOT_FMT][FMT_WIDE_BIT];
        view.stereo    = st_q.regs[SLOT_FMT][FMT_STEREO_BIT];
        view.sgn       = st_q.regs[SLOT_FMT][FMT_SIGNED_BIT];
    end

    assign rd_valid = st_q.rd_valid;
    assign rd_byte  = st_q.rd_byte;
    assign reinit   = st_q.reinit;

    assert_masked_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.regs[SLOT_IRQ_CTL][3:0] == 4'h0) && (st_q.regs[SLOT_DRQ_CTL][3:0] == 4'h0) &&
        (st_q.regs[SLOT_XFER][7:4] == 4'h0));

    assert_rd_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);

endmodule

// File: rtl/ext_dma_ctrl.sv
module ext_dma_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic run_cond,
    input  logic reinit,
    output logic active,
    output logic start_pulse,
    output logic stop_pulse
);

    typedef struct packed {
        logic active;
        logic start;
        logic stop;
    } run_t;

    run_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.stop  = 1'b0;
        if (st_q.active && (!run_cond || reinit)) begin
            // stop now; the idle branch restarts next cycle if the condition still holds
            st_d.stop   = 1'b1;
            st_d.active = 1'b0;
        end else if (!st_q.active && run_cond) begin
            st_d.start  = 1'b1;
            st_d.active = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active      = st_q.active;
    assign start_pulse = st_q.start;
    assign stop_pulse  = st_q.stop;

    assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_pulse && stop_pulse));

    assert_start_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> run_cond);

    assert_reinit_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && reinit) |=> (stop_pulse && !active));

endmodule

// File: rtl/ext_dsp_dma.sv
module ext_dsp_dma
    import ext_dsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic [BYTE_W-1:0] host_byte,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              dma_req,
    output logic              dma_start,
    output logic              dma_stop,
    output logic              fmt_16bit,
    output logic              fmt_stereo,
    output logic              fmt_signed,
    output logic              auto_init,
    output logic              capture,
    output logic [LEN_W-1:0]  xfer_len,
    output logic              rate_hiclk,
    output logic [BYTE_W-1:0] rate_div
);

    localparam logic [LEN_W-1:0]  FULL_LEN = LEN_W'(1) << CNT_W;
    localparam logic [BYTE_W-1:0] HALF_DIV = BYTE_W'(1) << (BYTE_W - 1);

    logic              wr_stb;
    logic              rd_stb;
    logic [BYTE_W-1:0] acc_addr;
    logic [BYTE_W-1:0] acc_data;
    ctrl_view_t        view;
    logic              reinit;
    logic              run_cond;

    ext_cmd_parser u_parser (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (host_valid),
        .in_byte  (host_byte),
        .wr_stb   (wr_stb),
        .rd_stb   (rd_stb),
        .acc_addr (acc_addr),
        .acc_data (acc_data)
    );

    ext_reg_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .rd_stb   (rd_stb),
        .acc_addr (acc_addr),
        .acc_data (acc_data),
        .view     (view),
        .rd_valid (rd_valid),
        .rd_byte  (rd_byte),
        .reinit   (reinit)
    );

    assign run_cond = view.xfer_en & view.drq_gate;

    ext_dma_ctrl u_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_cond    (run_cond),
        .reinit      (reinit),
        .active      (dma_req),
        .start_pulse (dma_start),
        .stop_pulse  (dma_stop)
    );

    assign fmt_16bit  = view.wide;
    assign fmt_stereo = view.stereo;
    assign fmt_signed = view.sgn;
    assign auto_init  = view.auto_init;
    assign capture    = view.capture;

    // counter runs up to zero, so the length is the two's complement of the reload value
    assign xfer_len   = FULL_LEN - {1'b0, view.count};

    assign rate_hiclk = view.rate[RATE_CLKSEL_BIT];
    assign rate_div   = rate_hiclk ? (BYTE_W'(0) - view.rate) : (HALF_DIV - view.rate);

    assert_req_low_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_stop |-> !dma_req);

endmodule

// File: tb/ext_dsp_dma_tb.sv
module ext_dsp_dma_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic [7:0]  host_byte = 8'h00;
    logic        rd_valid;
    logic [7:0]  rd_byte;
    logic        dma_req, dma_start, dma_stop;
    logic        fmt_16bit, fmt_stereo, fmt_signed, auto_init, capture;
    logic [16:0] xfer_len;
    logic        rate_hiclk;
    logic [7:0]  rate_div;

    ext_dsp_dma u_dut (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_byte(host_byte),
        .rd_valid(rd_valid), .rd_byte(rd_byte), .dma_req(dma_req),
        .dma_start(dma_start), .dma_stop(dma_stop), .fmt_16bit(fmt_16bit),
        .fmt_stereo(fmt_stereo), .fmt_signed(fmt_signed), .auto_init(auto_init),
        .capture(capture), .xfer_len(xfer_len), .rate_hiclk(rate_hiclk),
        .rate_div(rate_div)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int n_start = 0;
    int n_stop = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit readable(input logic [7:0] a);
        return a inside {8'hA1, 8'hA2, 8'hA4, 8'hA5, 8'hA8, 8'hB1, 8'hB2,
                         8'hB5, 8'hB6, 8'hB7, 8'hB8, 8'hB9, 8'hBA, 8'hBB};
    endfunction

    // ---------------- reference model ----------------
    logic [7:0] mreg [0:255];
    bit         m_ext, m_wait, m_act, m_pend, live;
    logic [7:0] m_cmd;
    bit         imm_rdv;
    logic [7:0] imm_rdb;
    bit         vis_rdv;
    logic [7:0] vis_rdb;
    logic [7:0] vis_a1, vis_a4, vis_a5, vis_b7, vis_b8;
    logic [2:0] dq1, dq2, vis_d;   // {req, start, stop}

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mreg[i] = 8'h00;
            m_ext = 0; m_wait = 0; m_act = 0; m_pend = 0; m_cmd = 8'h00;
            imm_rdv = 0; imm_rdb = 8'h00; vis_rdv = 0; vis_rdb = 8'h00;
            vis_a1 = 0; vis_a4 = 0; vis_a5 = 0; vis_b7 = 0; vis_b8 = 0;
            dq1 = 3'b000; dq2 = 3'b000; vis_d = 3'b000; live = 0;
        end else begin
            bit s_start, s_stop, rdv, wrote, reinit, cond;
            logic [7:0] rdb, oldv, nv, msk, ch;
            live = 1;
            vis_rdv = imm_rdv; vis_rdb = imm_rdb;
            vis_a1 = mreg[8'hA1]; vis_a4 = mreg[8'hA4]; vis_a5 = mreg[8'hA5];
            vis_b7 = mreg[8'hB7]; vis_b8 = mreg[8'hB8];
            vis_d = dq2; dq2 = dq1;
            s_start = 0; s_stop = 0; rdv = 0; rdb = imm_rdb; wrote = 0; reinit = 0;
            if (m_pend) begin
                m_pend = 0;
                if (mreg[8'hB8][0] && mreg[8'hB2][6]) begin s_start = 1; m_act = 1; end
            end
            if (host_valid) begin
                if (m_wait) begin
                    m_wait = 0;
                    if (m_cmd == 8'hC0) begin
                        rdv = 1;
                        rdb = readable(host_byte) ? mreg[host_byte] : 8'hFF;
                    end else if (m_ext && readable(m_cmd)) begin
                        msk = (m_cmd == 8'hB1 || m_cmd == 8'hB2) ? 8'hF0 :
                              (m_cmd == 8'hB8) ? 8'h0F : 8'hFF;
                        oldv = mreg[m_cmd];
                        nv = (oldv & ~msk) | (host_byte & msk);
                        ch = oldv ^ nv;
                        mreg[m_cmd] = nv;
                        wrote = 1;
                        if (m_cmd == 8'hA1) reinit = 1;
                        if (m_cmd == 8'hB7 && (ch[2] || ch[3])) reinit = 1;
                        if (m_cmd == 8'hA8 && (ch[0] || ch[1])) reinit = 1;
                        if (m_cmd == 8'hB8 && (ch[1] || ch[3])) reinit = 1;
                    end
                end else if ((host_byte >= 8'hA0 && host_byte <= 8'hBF) || host_byte == 8'hC0) begin
                    m_wait = 1; m_cmd = host_byte;
                end else if (host_byte == 8'hC6) m_ext = 1;
                else if (host_byte == 8'hC7) m_ext = 0;
            end
            if (wrote) begin
                cond = mreg[8'hB8][0] && mreg[8'hB2][6];
                if (m_act && (reinit || !cond)) begin
                    s_stop = 1; m_act = 0; m_pend = cond;
                end else if (!m_act && cond) begin
                    s_start = 1; m_act = 1;
                end
            end
            imm_rdv = rdv; imm_rdb = rdb;
            dq1 = {m_act, s_start, s_stop};
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n && live) begin
            logic [7:0] ediv;
            ediv = vis_a1[7] ? 8'(9'd256 - {1'b0, vis_a1}) : 8'(8'd128 - vis_a1);
            chk("R3 rd_valid", 32'(rd_valid), 32'(vis_rdv));
            if (vis_rdv) chk("R3 rd_byte", 32'(rd_byte), 32'(vis_rdb));
            chk("R5 fmt_16bit", 32'(fmt_16bit), 32'(vis_b7[2]));
            chk("R5 fmt_stereo", 32'(fmt_stereo), 32'(vis_b7[3]));
            chk("R5 fmt_signed", 32'(fmt_signed), 32'(vis_b7[5]));
            chk("R5 auto_init", 32'(auto_init), 32'(vis_b8[2]));
            chk("R5 capture", 32'(capture), 32'(vis_b8[3]));
            chk("R6 xfer_len", 32'(xfer_len), 32'(17'h10000 - {1'b0, vis_a5, vis_a4}));
            chk("R7 rate_hiclk", 32'(rate_hiclk), 32'(vis_a1[7]));
            chk("R7 rate_div", 32'(rate_div), 32'(ediv));
            chk("R8 dma_req", 32'(dma_req), 32'(vis_d[2]));
            chk("R8 dma_start", 32'(dma_start), 32'(vis_d[1]));
            chk("R9 dma_stop", 32'(dma_stop), 32'(vis_d[0]));
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (dma_start) n_start++;
            if (dma_stop) n_stop++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        host_valid = 1'b1;
        host_byte  = b;
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        send(a);
        send(d);
        repeat (4) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        send(8'hC0);
        @(negedge clk);
        host_valid = 1'b1;
        host_byte  = a;
        @(negedge clk);
        host_valid = 1'b0;
        @(negedge clk);
        chk("R3 read strobe", 32'(rd_valid), 32'd1);
        v = rd_byte;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulses(input string tag, input int s0, input int p0,
                          input int ds, input int dp);
        chk({tag, " start count"}, 32'(n_start - s0), 32'(ds));
        chk({tag, " stop count"}, 32'(n_stop - p0), 32'(dp));
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int s0, p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R11 reset state
        chk("R11 dma_req", 32'(dma_req), 0);
        chk("R11 dma_start", 32'(dma_start), 0);
        chk("R11 dma_stop", 32'(dma_stop), 0);
        chk("R11 rd_valid", 32'(rd_valid), 0);
        chk("R11 xfer_len", 32'(xfer_len), 32'h10000);
        chk("R11 rate_div", 32'(rate_div), 32'h80);
        rd(8'hB7, v); chk("R11 reg B7 cleared", 32'(v), 0);

        // R2 writes dropped while extended mode is off
        wr(8'hA4, 8'h55);
        rd(8'hA4, v); chk("R2 write ignored when off", 32'(v), 0);
        send(8'h40); send(8'hC1);           // no data byte consumed
        send(8'hC6);                        // R1 enable
        wr(8'hA5, 8'hFC);
        rd(8'hA5, v); chk("R1 R2 write accepted after enable", 32'(v), 32'hFC);
        wr(8'hA4, 8'h00);
        rd(8'hA0, v); chk("R3 unknown reg A0", 32'(v), 32'hFF);
        rd(8'h10, v); chk("R3 unknown reg 10", 32'(v), 32'hFF);

        // R4 masks
        wr(8'hB1, 8'hFF); rd(8'hB1, v); chk("R4 B1 mask", 32'(v), 32'hF0);
        wr(8'hB2, 8'h0F); rd(8'hB2, v); chk("R4 B2 mask", 32'(v), 32'h00);
        wr(8'hB8, 8'hF5); rd(8'hB8, v); chk("R4 B8 mask", 32'(v), 32'h05);
        chk("R8 no run without gate", 32'(dma_req), 0);

        wr(8'hB7, 8'h2C);
        wr(8'hA1, 8'h90);
        chk("R7 divisor hi clock", 32'(rate_div), 32'd112);

        s0 = n_start; p0 = n_stop;
        wr(8'hB2, 8'h40);
        pulses("R8 start", s0, p0, 1, 0);
        chk("R8 running", 32'(dma_req), 1);

        s0 = n_start; p0 = n_stop;
        wr(8'hB7, 8'h28);
        pulses("R9 width change", s0, p0, 1, 1);
        s0 = n_start; p0 = n_stop;
        wr(8'hB7, 8'h08);
        pulses("R10 sign change", s0, p0, 0, 0);
        wr(8'hB8, 8'h01);
        pulses("R10 auto change", s0, p0, 0, 0);
        wr(8'hA8, 8'h10);
        pulses("R10 analog upper bits", s0, p0, 0, 0);
        s0 = n_start; p0 = n_stop;
        wr(8'hA8, 8'h11);
        pulses("R9 channel mode", s0, p0, 1, 1);
        s0 = n_start; p0 = n_stop;
        wr(8'hA1, 8'h90);
        pulses("R9 rate rewrite", s0, p0, 1, 1);
        s0 = n_start; p0 = n_stop;
        wr(8'hB8, 8'h09);
        pulses("R9 direction bit", s0, p0, 1, 1);

        s0 = n_start; p0 = n_stop;
        wr(8'hB2, 8'h00);
        pulses("R8 gate off", s0, p0, 0, 1);
        chk("R8 stopped", 32'(dma_req), 0);
        s0 = n_start; p0 = n_stop;
        wr(8'hB2, 8'h40);
        pulses("R8 gate on", s0, p0, 1, 0);
        s0 = n_start; p0 = n_stop;
        wr(8'hB8, 8'h08);
        pulses("R8 enable off", s0, p0, 0, 1);

        send(8'hC7);                        // R1 disable
        s0 = n_start; p0 = n_stop;
        wr(8'hB8, 8'h09);
        pulses("R1 write after disable", s0, p0, 0, 0);
        rd(8'hB8, v); chk("R1 B8 unchanged", 32'(v), 32'h08);

        send(8'hC6);
        wr(8'hA1, 8'h40);
        chk("R7 divisor low clock", 32'(rate_div), 32'd64);
        chk("R7 clock select", 32'(rate_hiclk), 0);
        wr(8'hA5, 8'h00);
        chk("R6 zero reload", 32'(xfer_len), 32'h10000);
        wr(8'hA4, 8'h01);
        chk("R6 reload one", 32'(xfer_len), 32'hFFFF);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule